// File: doc/BRIEF.md
# MAC Host Management Interface

This block is the host-side management slave of an Ethernet MAC. The host presents one access per cycle through a request/ready handshake. The block decodes each accepted access as one of three kinds: a configuration register access, an access to a small table of 48-bit station addresses, or a management transaction on an MDIO pin trio. Configuration words hold the MAC's own unicast address and the MDC clock divisor. The address table is written one word at a time, and a read returns the whole entry over two consecutive cycles.

MDIO transactions are full 64-bit frames. Each frame is serialised on MDC, a clock divided down from the host clock. The data output and the output enable are separate pins, so an external tristate buffer can form the bidirectional line. Read results come back on the host read bus when ready returns. Ready stays low while a frame is on the wire, and any request made in that time is dropped.

Top module: `mac_host_mgmt`

## Requirements
- R1: An access is accepted when `host_req` and `host_rdy` are both high at a clock edge. `host_sel`=1 selects MDIO. `host_sel`=0 with `host_addr[9]`=1 selects the configuration registers. `host_sel`=0 with `host_addr[9]`=0 selects the address table.
- R2: For configuration and table accesses, `host_op[1]`=0 means write and `host_op[1]`=1 means read. `host_op[0]` has no effect.
- R3: A configuration read places data on `host_rdata` after the accepting edge. The offset is `host_addr[8:0]`. Offset 0 is unicast bits 31:0, with the first address byte in bits 7:0. Offset 1 is unicast bits 47:32 in bits 15:0, and bits 31:16 read 0. Offset 2 is the MDC divisor in its low 6 bits. Every other offset reads 0.
- R4: Table entry index is `host_addr[2:1]` and `host_addr[0]` picks the word to write. Word 0 takes `host_wdata[31:0]` as entry bits 31:0. Word 1 takes `host_wdata[15:0]` as bits 47:32. A table read shows bits 31:0 after the accepting edge and bits 47:32 in bits 15:0 (upper half 0) one cycle later. `host_rdy` is low during that second cycle.
- R5: While a frame runs, MDC has a period of 2×(divisor+1) host cycles. A frame lasts 128×(divisor+1) cycles from the accepting edge until `host_rdy` returns.
- R6: While the divisor is 0, an MDIO request is ignored: `host_rdy` stays high and MDC stays low.
- R7: The frame is 32 ones, then 01, then the opcode, then PHY address `host_addr[9:5]`, register address `host_addr[4:0]`, a 2-bit turnaround and 16 data bits, all MSB first. `host_op` 01 is write and 10 is read. MDIO requests with opcode 00 or 11 are ignored. `mdio_out` changes only on the falling edge of MDC.
- R8: A write drives turnaround 1 then 0 and data `host_wdata[15:0]`. `mdio_tri` is low for the whole write frame.
- R9: A read drives the first 46 bits and raises `mdio_tri` from the turnaround onward. It samples `mdio_in` on rising MDC. The 16 bits appear on `host_rdata[15:0]` (upper 0) in the cycle `host_rdy` returns.
- R10: `host_rdy` is low from an accepted MDIO request until its frame ends. Requests made while `host_rdy` is low are ignored.
- R11: With no frame running, `mdio_tri`=1, `mdio_out`=1 and `mdc`=0.
- R12: After reset, `host_rdy`=1, `host_rdata`=0, and all configuration words and table entries are 0.
- R13: `host_rdata` changes only through a read. Writes leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request |
| host_sel | input | 1 | 1 selects an MDIO transaction |
| host_op | input | 2 | Access opcode |
| host_addr | input | 10 | Access address |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data |
| host_rdy | output | 1 | Block can accept a request |
| mdc | output | 1 | Management clock |
| mdio_in | input | 1 | Management data from the line |
| mdio_out | output | 1 | Management data to the line |
| mdio_tri | output | 1 | 1 releases the line |

## Verification
The end of an MDIO read loads the read bus, and a host request can arrive in the very cycle ready returns. The bench drives a configuration read at the first negedge where ready is seen high. It checks that the MDIO result is visible on that negedge and that the new read replaces it one edge later. A second coincidence is provoked by issuing a configuration write during the second word of a table read. The bench judges it by the table's upper half appearing as expected and a later readback showing the write was dropped.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CFG  = 2'd1,
    ACC_TBL  = 2'd2,
    ACC_MDIO = 2'd3
  } acc_kind_e;

  localparam logic [1:0] MDIO_WR = 2'b01;
  localparam logic [1:0] MDIO_RD = 2'b10;

  localparam int FRAME_BITS = 64;
  localparam int PRE_BITS   = 32;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;

  function automatic acc_kind_e classify(input logic sel, input logic a9);
    if (sel)     return ACC_MDIO;
    else if (a9) return ACC_CFG;
    else         return ACC_TBL;
  endfunction
endpackage

// File: rtl/mgmt_cfg_regs.sv
`timescale 1ns/1ps
module mgmt_cfg_regs #(
  parameter int DIVW        = 6,
  parameter int TBL_ENTRIES = 4,
  localparam int IDXW       = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [8:0]      cfg_off,
  input  logic            tbl_we,
  input  logic [IDXW-1:0] tbl_idx,
  input  logic            tbl_word,
  input  logic [31:0]     wdata,
  output logic [31:0]     cfg_rdata,
  output logic [31:0]     tbl_lo,
  output logic [15:0]     tbl_hi,
  output logic [DIVW-1:0] div
);
  logic [47:0]     uc_q, uc_d;
  logic [DIVW-1:0] div_q, div_d;
  logic [47:0]     ent_all [TBL_ENTRIES];

  always_comb begin
    uc_d  = uc_q;
    div_d = div_q;
    if (cfg_we) begin
      case (cfg_off)
        9'd0:    uc_d[31:0]  = wdata;
        9'd1:    uc_d[47:32] = wdata[15:0];
        9'd2:    div_d       = wdata[DIVW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uc_q  <= '0;
      div_q <= '0;
    end else if (cfg_we) begin
      uc_q  <= uc_d;
      div_q <= div_d;
    end
  end

  always_comb begin
    case (cfg_off)
      9'd0:    cfg_rdata = uc_q[31:0];
      9'd1:    cfg_rdata = {16'h0000, uc_q[47:32]};
      9'd2:    cfg_rdata = 32'(div_q);
      default: cfg_rdata = '0;
    endcase
  end

  for (genvar e = 0; e < TBL_ENTRIES; e++) begin : g_entry
    logic        hit;
    logic [47:0] ent_q, ent_d;
    assign hit = tbl_we && (tbl_idx == IDXW'(e));
    always_comb begin
      ent_d = ent_q;
      if (tbl_word) ent_d[47:32] = wdata[15:0];
      else          ent_d[31:0]  = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ent_q <= '0;
      else if (hit) ent_q <= ent_d;
    end
    assign ent_all[e] = ent_q;
  end

  assign tbl_lo = ent_all[tbl_idx][31:0];
  assign tbl_hi = ent_all[tbl_idx][47:32];
  assign div    = div_q;

  assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(div));
endmodule

// File: rtl/mgmt_mdio_engine.sv
`timescale 1ns/1ps
module mgmt_mdio_engine #(
  parameter int DIVW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            start_rd,
  input  logic [4:0]      phy_ad,
  input  logic [4:0]      reg_ad,
  input  logic [15:0]     wr_data,
  input  logic [DIVW-1:0] div,
  output logic            busy,
  output logic            rd_mode,
  output logic            finish,
  output logic [15:0]     rd_word,
  output logic            mdc,
  input  logic            mdio_in,
  output logic            mdio_out,
  output logic            mdio_tri
);
  import mgmt_pkg::*;
  localparam int FB = FRAME_BITS;
  localparam int CW = $clog2(FB);

  logic            busy_q, busy_d;
  logic            rd_q, rd_d;
  logic            mdc_q, mdc_d;
  logic [DIVW-1:0] cnt_q, cnt_d, dv_q, dv_d;
  logic [CW-1:0]   bit_q, bit_d;
  logic [FB-1:0]   sh_q, sh_d;
  logic [15:0]     rs_q, rs_d;
  logic            tick, rising, falling;
  logic [FB-1:0]   frame;

  assign tick    = busy_q && (cnt_q == dv_q);
  assign rising  = tick && !mdc_q;
  assign falling = tick && mdc_q;
  assign finish  = falling && (bit_q == CW'(FB-1));

  assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                  start_rd ? MDIO_RD : MDIO_WR,
                  phy_ad, reg_ad,
                  start_rd ? 2'b11 : 2'b10,
                  start_rd ? 16'hFFFF : wr_data};

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    mdc_d  = mdc_q;
    cnt_d  = cnt_q;
    dv_d   = dv_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rs_d   = rs_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      rd_d   = start_rd;
      mdc_d  = 1'b0;
      cnt_d  = '0;
      dv_d   = div;
      bit_d  = '0;
      sh_d   = frame;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
      if (rising) begin
        if (rd_q && (bit_q >= CW'(DATA_POS))) rs_d = {rs_q[14:0], mdio_in};
      end else if (finish) begin
        busy_d = 1'b0;
      end else begin
        bit_d = bit_q + CW'(1);
        sh_d  = {sh_q[FB-2:0], 1'b0};
      end
    end else if (busy_q) begin
      cnt_d = cnt_q + DIVW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      mdc_q  <= 1'b0;
      cnt_q  <= '0;
      dv_q   <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rs_q   <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      mdc_q  <= mdc_d;
      cnt_q  <= cnt_d;
      dv_q   <= dv_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rs_q   <= rs_d;
    end
  end

  assign busy     = busy_q;
  assign rd_mode  = rd_q;
  assign rd_word  = rs_q;
  assign mdc      = mdc_q;
  assign mdio_out = busy_q ? sh_q[FB-1] : 1'b1;
  assign mdio_tri = !busy_q || (rd_q && (bit_q >= CW'(TA_POS)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && mdio_tri));
  assert_write_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !rd_q) |-> !mdio_tri);
  assert_out_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !falling && !start) |=> $stable(mdio_out));
  assert_mdc_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(mdc));
endmodule

// File: rtl/mac_host_mgmt.sv
`timescale 1ns/1ps
module mac_host_mgmt #(
  parameter int DIVW        = 6,
  parameter int TBL_ENTRIES = 4,
  localparam int IDXW       = (TBL_ENTRIES > 1) ? $clog2(TBL_ENTRIES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_sel,
  input  logic [1:0]  host_op,
  input  logic [9:0]  host_addr,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rdy,
  output logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_tri
);
  import mgmt_pkg::*;

  acc_kind_e       kind;
  logic            accept, is_wr, op_ok;
  logic            cfg_we, cfg_rd, tbl_we, tbl_rd, mdio_start;
  logic [31:0]     cfg_rdata, tbl_lo;
  logic [15:0]     tbl_hi;
  logic [DIVW-1:0] div;
  logic            m_busy, m_rd, m_finish;
  logic [15:0]     m_word;
  logic [31:0]     rdata_q, rdata_d;
  logic [15:0]     hi_q, hi_d;
  logic            pend_q, pend_d;

  assign accept     = host_req && host_rdy;
  assign kind       = accept ? classify(host_sel, host_addr[9]) : ACC_NONE;
  assign is_wr      = !host_op[1];
  assign op_ok      = (host_op == MDIO_WR) || (host_op == MDIO_RD);
  assign cfg_we     = (kind == ACC_CFG) && is_wr;
  assign cfg_rd     = (kind == ACC_CFG) && !is_wr;
  assign tbl_we     = (kind == ACC_TBL) && is_wr;
  assign tbl_rd     = (kind == ACC_TBL) && !is_wr;
  assign mdio_start = (kind == ACC_MDIO) && op_ok && (div != '0);

  mgmt_cfg_regs #(.DIVW(DIVW), .TBL_ENTRIES(TBL_ENTRIES)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_off   (host_addr[8:0]),
    .tbl_we    (tbl_we),
    .tbl_idx   (host_addr[IDXW:1]),
    .tbl_word  (host_addr[0]),
    .wdata     (host_wdata),
    .cfg_rdata (cfg_rdata),
    .tbl_lo    (tbl_lo),
    .tbl_hi    (tbl_hi),
    .div       (div)
  );

  mgmt_mdio_engine #(.DIVW(DIVW)) u_mdio (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (mdio_start),
    .start_rd (host_op == MDIO_RD),
    .phy_ad   (host_addr[9:5]),
    .reg_ad   (host_addr[4:0]),
    .wr_data  (host_wdata[15:0]),
    .div      (div),
    .busy     (m_busy),
    .rd_mode  (m_rd),
    .finish   (m_finish),
    .rd_word  (m_word),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .mdio_out (mdio_out),
    .mdio_tri (mdio_tri)
  );

  always_comb begin
    rdata_d = rdata_q;
    if (m_finish && m_rd)  rdata_d = {16'h0000, m_word};
    else if (pend_q)       rdata_d = {16'h0000, hi_q};
    else if (cfg_rd)       rdata_d = cfg_rdata;
    else if (tbl_rd)       rdata_d = tbl_lo;
    hi_d   = tbl_rd ? tbl_hi : hi_q;
    pend_d = tbl_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      hi_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      rdata_q <= rdata_d;
      hi_q    <= hi_d;
      pend_q  <= pend_d;
    end
  end

  assign host_rdata = rdata_q;
  assign host_rdy   = !m_busy && !pend_q;

  assert_mdio_holds_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_rdy && host_sel && op_ok && (div != '0)) |=> !host_rdy);
  assert_tbl_second_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd |=> !host_rdy);
  assert_rdata_only_on_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_rd && !tbl_rd && !pend_q && !m_finish) |=> $stable(host_rdata));
  assert_zero_div_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rdy && (div == '0) && !tbl_rd) |=> host_rdy);
endmodule

// File: tb/mac_host_mgmt_test.sv
`timescale 1ns/1ps
module mac_host_mgmt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_req, host_sel;
  logic [1:0]  host_op;
  logic [9:0]  host_addr;
  logic [31:0] host_wdata, host_rdata;
  logic        host_rdy, mdc, mdio_in, mdio_out, mdio_tri;

  always #2 clk = ~clk;

  mac_host_mgmt uut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_sel(host_sel),
    .host_op(host_op), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rdy(host_rdy), .mdc(mdc),
    .mdio_in(mdio_in), .mdio_out(mdio_out), .mdio_tri(mdio_tri)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // line monitor: one capture per rising MDC, bit index = rise count mod 64
  logic        mdc_prev = 1'b0;
  int          rc = 0, cyc = 0, last_rise = 0, last_per = 0;
  logic        cap_out [64];
  logic        cap_tri [64];
  logic [15:0] pat = 16'h0000;
  logic [5:0]  ri;

  always @(negedge clk) begin
    cyc++;
    if (mdc && !mdc_prev) begin
      cap_out[rc % 64] = mdio_out;
      cap_tri[rc % 64] = mdio_tri;
      last_per  = cyc - last_rise;
      last_rise = cyc;
      rc++;
    end
    mdc_prev = mdc;
  end

  always_comb begin
    ri = 6'(rc);
    mdio_in = (ri >= 6'd48) ? pat[6'd63 - ri] : 1'b1;
  end

  task automatic acc(input logic s, input logic [1:0] o, input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    host_req = 1'b1; host_sel = s; host_op = o; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 config read, 2 table read
    logic [1:0]  op;
    logic [9:0]  addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [15:0] exp2;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{2'd0, 2'b01, 10'h200, 32'hDDCCBBAA, 32'h0, 16'h0},         // op[0] set, still a write
    '{2'd0, 2'b00, 10'h201, 32'hABCDFFEE, 32'h0, 16'h0},
    '{2'd1, 2'b10, 10'h200, 32'h0, 32'hDDCCBBAA, 16'h0},
    '{2'd1, 2'b11, 10'h201, 32'h0, 32'h0000FFEE, 16'h0},
    '{2'd0, 2'b00, 10'h202, 32'h00000043, 32'h0, 16'h0},
    '{2'd1, 2'b10, 10'h202, 32'h0, 32'h00000003, 16'h0},
    '{2'd1, 2'b10, 10'h205, 32'h0, 32'h00000000, 16'h0},
    '{2'd0, 2'b00, 10'h002, 32'h11223344, 32'h0, 16'h0},
    '{2'd0, 2'b01, 10'h003, 32'hFFFF5566, 32'h0, 16'h0},
    '{2'd2, 2'b10, 10'h002, 32'h0, 32'h11223344, 16'h5566},
    '{2'd2, 2'b11, 10'h007, 32'h0, 32'h00000000, 16'h0000},
    '{2'd0, 2'b00, 10'h006, 32'hCAFEF00D, 32'h0, 16'h0},
    '{2'd2, 2'b10, 10'h006, 32'h0, 32'hCAFEF00D, 16'h0000},
    '{2'd2, 2'b10, 10'h003, 32'h0, 32'h11223344, 16'h5566}
  };

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] last_rd;
    logic [63:0] expf;
    int k, bad, seen;
    host_req = 0; host_sel = 0; host_op = 0; host_addr = 0; host_wdata = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(host_rdy == 1'b1, "R12 ready", 64'(host_rdy), 64'd1);
    chk(host_rdata == 32'h0, "R12 rdata", 64'(host_rdata), 64'd0);
    chk({mdc, mdio_tri, mdio_out} == 3'b011, "R11 idle pins", 64'({mdc, mdio_tri, mdio_out}), 64'd3);
    acc(1'b0, 2'b10, 10'h201, 32'h0);
    chk(host_rdata == 32'h0, "R12 unicast hi zero", 64'(host_rdata), 64'd0);
    last_rd = 32'h0;

    // R6: divisor still zero, MDIO request dropped
    acc(1'b1, 2'b01, 10'h3FF, 32'h1234);
    chk(host_rdy == 1'b1, "R6 ready stays high", 64'(host_rdy), 64'd1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mdc) seen++;
    end
    chk(seen == 0 && rc == 0, "R6 no mdc activity", 64'(seen), 64'd0);

    // table-driven configuration and address table accesses
    for (int v = 0; v < 14; v++) begin
      acc(1'b0, VEC[v].op, VEC[v].addr, VEC[v].wd);
      if (VEC[v].kind == 2'd0) begin
        chk(host_rdata == last_rd, "R13 write leaves rdata", 64'(host_rdata), 64'(last_rd));
      end else if (VEC[v].kind == 2'd1) begin
        chk(host_rdata == VEC[v].exp, "R2 R3 config read", 64'(host_rdata), 64'(VEC[v].exp));
        last_rd = VEC[v].exp;
      end else begin
        chk(host_rdata == VEC[v].exp, "R1 R4 table low word", 64'(host_rdata), 64'(VEC[v].exp));
        chk(host_rdy == 1'b0, "R4 ready low in second cycle", 64'(host_rdy), 64'd0);
        @(negedge clk);
        chk(host_rdata == {16'h0, VEC[v].exp2}, "R4 table high word", 64'(host_rdata), 64'({16'h0, VEC[v].exp2}));
        last_rd = {16'h0, VEC[v].exp2};
      end
    end

    // R7: invalid MDIO opcode ignored (divisor is 3)
    acc(1'b1, 2'b11, 10'h155, 32'h0);
    chk(host_rdy == 1'b1, "R7 bad opcode ignored", 64'(host_rdy), 64'd1);
    repeat (12) @(negedge clk);
    chk(rc == 0, "R7 bad opcode no frame", 64'(rc), 64'd0);

    // MDIO write, divisor 3
    acc(1'b1, 2'b01, {5'h13, 5'h0A}, 32'h0000A5C3);
    chk(host_rdy == 1'b0, "R10 ready drops", 64'(host_rdy), 64'd0);
    acc(1'b0, 2'b00, 10'h202, 32'h00000007);   // must be dropped (R10)
    k = 2;
    while (!host_rdy && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k == 512, "R5 R10 write frame length", 64'(k), 64'd512);
    chk(last_per == 8, "R5 mdc period div3", 64'(last_per), 64'd8);
    expf = {32'hFFFFFFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, 16'hA5C3};
    bad = 0;
    for (int i = 0; i < 64; i++) if (cap_out[i] !== expf[63 - i]) bad++;
    chk(bad == 0, "R7 R8 write frame bits", 64'(bad), 64'd0);
    bad = 0;
    for (int i = 0; i < 64; i++) if (cap_tri[i] !== 1'b0) bad++;
    chk(bad == 0, "R8 line driven on write", 64'(bad), 64'd0);
    chk(host_rdata == last_rd, "R13 write frame leaves rdata", 64'(host_rdata), 64'(last_rd));
    acc(1'b0, 2'b10, 10'h202, 32'h0);
    chk(host_rdata == 32'h3, "R10 busy write dropped", 64'(host_rdata), 64'd3);

    // MDIO read, divisor 1, then a request on the first ready cycle
    acc(1'b0, 2'b00, 10'h202, 32'h00000001);
    pat = 16'h3C96;
    acc(1'b1, 2'b10, {5'h1F, 5'h00}, 32'hFFFFFFFF);
    k = 0;
    while (!host_rdy && k < 5000) begin
      @(negedge clk);
      k++;
    end
    chk(k == 256, "R5 R10 read frame length", 64'(k), 64'd256);
    chk(host_rdata == 32'h00003C96, "R9 read result", 64'(host_rdata), 64'h3C96);
    host_req = 1'b1; host_sel = 1'b0; host_op = 2'b10; host_addr = 10'h200;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_rdata == 32'hDDCCBBAA, "R1 R10 request on first ready cycle", 64'(host_rdata), 64'hDDCCBBAA);
    chk(last_per == 4, "R5 mdc period div1", 64'(last_per), 64'd4);
    expf = {32'hFFFFFFFF, 2'b01, 2'b10, 5'h1F, 5'h00, 18'h0};
    bad = 0;
    for (int i = 0; i < 46; i++) if (cap_out[i] !== expf[63 - i]) bad++;
    chk(bad == 0, "R7 read frame header", 64'(bad), 64'd0);
    bad = 0;
    for (int i = 0; i < 64; i++) if (cap_tri[i] !== (i >= 46)) bad++;
    chk(bad == 0, "R9 release from turnaround", 64'(bad), 64'd0);
    chk({mdc, mdio_tri, mdio_out} == 3'b011, "R11 idle after frame", 64'({mdc, mdio_tri, mdio_out}), 64'd3);

    // R4: request during the table's second word is dropped
    acc(1'b0, 2'b10, 10'h002, 32'h0);
    chk(host_rdata == 32'h11223344, "R4 low word", 64'(host_rdata), 64'h11223344);
    host_req = 1'b1; host_sel = 1'b0; host_op = 2'b00; host_addr = 10'h202; host_wdata = 32'h9;
    @(negedge clk);
    host_req = 1'b0;
    chk(host_rdata == 32'h00005566, "R4 high word", 64'(host_rdata), 64'h5566);
    acc(1'b0, 2'b10, 10'h202, 32'h0);
    chk(host_rdata == 32'h1, "R4 request in second cycle dropped", 64'(host_rdata), 64'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule